// File: doc/BRIEF.md
# Edge-Counting Phase Accumulator

This block counts transitions on a single input line that is not tied to the system clock. The line is sampled on every clock and the two most recent samples are held. A transition in the selected direction (low-to-high, or high-to-low when the direction select is set) is recognised from those two samples. Each recognised transition adds a programmable step value into a wide accumulator. Software can load the step value and the accumulator directly.

Typical use is frequency or event measurement. The step is set to 1, the accumulator is cleared, and its value is read after a known number of clocks. With a larger step the block acts as a scaled tally. Recognition is exact when the line stays at each level for at least one clock, which limits the counted edge rate to half the clock rate. Faster inputs alias downward. No synchronizer stage sits ahead of the sample history, so a transition reaches the accumulator output after the second rising clock edge that sees it.

Top module: `edge_accum_counter`

## Requirements
- R1: After reset, `acc_o` reads 0, the step register holds 0 and both history samples are 0.
- R2: `pin_i` is captured once on every rising clock edge into a two-entry history, with no added synchronizer. A level change that is present before clock edge N changes `acc_o` right after clock edge N+1.
- R3: With `fall_mode_i` = 0, an add occurs when the newer history sample is 1 and the older one is 0. The add sums the step register into the accumulator.
- R4: With `fall_mode_i` = 1, an add occurs when the newer history sample is 0 and the older one is 1.
- R5: On a clock with no detected transition and no load, the accumulator keeps its value, even while `pin_i` is held at a steady level.
- R6: An input that toggles on every clock causes an add on every second clock and never on two clocks in a row.
- R7: When `acc_we_i` is high, the accumulator takes `acc_wdata_i` on that edge. This load wins over an add in the same cycle.
- R8: The accumulator is W bits wide (default 32) and wraps modulo 2^W on an add.
- R9: When `inc_we_i` is high, the step register takes `inc_wdata_i`. An add on the same edge still uses the previous step value, and later adds use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| pin_i | input | 1 | Raw input line being counted |
| fall_mode_i | input | 1 | 0 counts low-to-high transitions, 1 counts high-to-low transitions |
| inc_we_i | input | 1 | Load strobe for the step register |
| inc_wdata_i | input | W | New step value |
| acc_we_i | input | 1 | Load strobe for the accumulator |
| acc_wdata_i | input | W | New accumulator value |
| acc_o | output | W | Current accumulator value |

## Verification
The assertions assume that `pin_i` and the control inputs are stable around each rising clock edge. They also assume that each level of `pin_i` lasts at least one clock, so that the history behaves as a clean shift register. The stimulus meets both assumptions by changing every input only on the falling clock edge. The fastest waveform it produces is a toggle on every clock, which is the counting limit. The bench never drives a faster input, so aliasing is not exercised.

// File: rtl/eac_pkg.sv
package eac_pkg;
  typedef enum logic {
    DIR_RISE = 1'b0,
    DIR_FALL = 1'b1
  } edge_dir_e;

  localparam int unsigned HIST_DEPTH = 2;
endpackage

// File: rtl/eac_rst_sync.sv
module eac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/eac_sampler.sv
module eac_sampler
  import eac_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic newer_o,
  output logic older_o
);
  logic [HIST_DEPTH-1:0] hist_q;
  logic [HIST_DEPTH-1:0] hist_d;

  always_comb begin
    hist_d = {hist_q[HIST_DEPTH-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
  end

  assign newer_o = hist_q[0];
  assign older_o = hist_q[1];

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> newer_o == $past(pin_i));
  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> older_o == $past(newer_o));
endmodule

// File: rtl/eac_edge_detect.sv
module eac_edge_detect
  import eac_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_i,
  input  logic newer_i,
  input  logic older_i,
  output logic hit_o
);
  edge_dir_e dir;
  logic rise_hit;
  logic fall_hit;

  always_comb begin
    dir      = edge_dir_e'(dir_i);
    rise_hit = newer_i & ~older_i;
    fall_hit = ~newer_i & older_i;
    unique case (dir)
      DIR_RISE: hit_o = rise_hit;
      DIR_FALL: hit_o = fall_hit;
      default:  hit_o = 1'b0;
    endcase
  end

  p_no_back_to_back_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && $stable(dir_i)) |=> !hit_o || (dir_i != $past(dir_i)));
endmodule

// File: rtl/eac_accum.sv
module eac_accum #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         add_i,
  input  logic         inc_we_i,
  input  logic [W-1:0] inc_wdata_i,
  input  logic         acc_we_i,
  input  logic [W-1:0] acc_wdata_i,
  output logic [W-1:0] acc_o
);
  logic [W-1:0] inc_q, inc_d;
  logic [W-1:0] acc_q, acc_d;
  logic         inc_en, acc_en;

  always_comb begin
    inc_en = inc_we_i;
    inc_d  = inc_wdata_i;
    acc_en = acc_we_i | add_i;
    if (acc_we_i) acc_d = acc_wdata_i;
    else          acc_d = acc_q + inc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     inc_q <= '0;
    else if (inc_en) inc_q <= inc_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_i && !acc_we_i) |=> acc_o == $past(acc_o));
  p_load_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_i |=> acc_o == $past(acc_wdata_i));
  p_add_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !acc_we_i) |=> acc_o == W'($past(acc_o) + $past(inc_q)));
  p_step_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_we_i |=> inc_q == $past(inc_wdata_i));
endmodule

// File: rtl/edge_accum_counter.sv
module edge_accum_counter #(
  parameter int unsigned W = 32,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pin_i,
  input  logic         fall_mode_i,
  input  logic         inc_we_i,
  input  logic [W-1:0] inc_wdata_i,
  input  logic         acc_we_i,
  input  logic [W-1:0] acc_wdata_i,
  output logic [W-1:0] acc_o
);
  logic rst_n;
  logic newer, older, hit;

  eac_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  eac_sampler u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .pin_i  (pin_i),
    .newer_o(newer),
    .older_o(older)
  );

  eac_edge_detect u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .dir_i  (fall_mode_i),
    .newer_i(newer),
    .older_i(older),
    .hit_o  (hit)
  );

  eac_accum #(.W(W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .add_i      (hit),
    .inc_we_i   (inc_we_i),
    .inc_wdata_i(inc_wdata_i),
    .acc_we_i   (acc_we_i),
    .acc_wdata_i(acc_wdata_i),
    .acc_o      (acc_o)
  );

  p_reset_clear_r1: assert property (@(posedge clk_i)
    (!rst_n) |-> acc_o == '0);
endmodule

// File: tb/edge_accum_counter_test.sv
module edge_accum_counter_test;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         pin, fall;
  logic         inc_we, acc_we;
  logic [W-1:0] inc_wd, acc_wd;
  logic [W-1:0] acc_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  logic [W-1:0] m_acc, m_inc;
  logic         m_new, m_old;

  always #2.5 clk = ~clk;

  edge_accum_counter #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .fall_mode_i(fall),
    .inc_we_i(inc_we), .inc_wdata_i(inc_wd),
    .acc_we_i(acc_we), .acc_wdata_i(acc_wd), .acc_o(acc_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: acc_o=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: drives one cycle on the falling edge and pushes the value
  // acc_o must show after the next rising edge.
  task automatic cyc(input logic p, input logic f, input logic iw, input logic [W-1:0] id,
                     input logic aw, input logic [W-1:0] ad, input string req);
    logic det;
    logic [W-1:0] nxt;
    @(negedge clk);
    pin = p; fall = f; inc_we = iw; inc_wd = id; acc_we = aw; acc_wd = ad;
    det = f ? (!m_new && m_old) : (m_new && !m_old);
    if (aw)       nxt = ad;
    else if (det) nxt = m_acc + m_inc;
    else          nxt = m_acc;
    m_acc = nxt;
    if (iw) m_inc = id;
    m_old = m_new;
    m_new = p;
    exp_q.push_back(nxt);
    tag_q.push_back(req);
  endtask

  task automatic run_pin(input logic p, input logic f, input int n, input string req);
    for (int i = 0; i < n; i++) cyc(p, f, 1'b0, '0, 1'b0, '0, req);
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, acc_o, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; pin = 1'b0; fall = 1'b0;
    inc_we = 1'b0; acc_we = 1'b0; inc_wd = '0; acc_wd = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check("R1 reset value", acc_o, '0);
    m_acc = '0; m_inc = '0; m_new = 1'b0; m_old = 1'b0;

    // R1: step resets to 0, so a rising edge adds nothing
    run_pin(1'b1, 1'b0, 3, "R1 step cleared");
    run_pin(1'b0, 1'b0, 2, "R1 step cleared");

    // R9: load step 3, then single rising edge (R2 latency, R3 rule)
    cyc(1'b0, 1'b0, 1'b1, 32'd3, 1'b0, '0, "R9 step load");
    run_pin(1'b1, 1'b0, 4, "R3 R2 rising edge");
    run_pin(1'b0, 1'b0, 4, "R5 hold low");
    run_pin(1'b1, 1'b0, 6, "R5 hold high");
    run_pin(1'b0, 1'b0, 2, "R3 rising");

    // R6: toggle every clock
    for (int i = 0; i < 12; i++) cyc(i[0], 1'b0, 1'b0, '0, 1'b0, '0, "R6 half rate");

    // R9: step change during toggling, same edge as an add uses old step
    cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R9 setup");
    cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, "R9 setup");
    cyc(1'b1, 1'b0, 1'b1, 32'd100, 1'b0, '0, "R9 old step on same edge");
    cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R9 new step");
    cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, "R9 new step");
    run_pin(1'b1, 1'b0, 3, "R9 new step");

    // R4: falling-edge mode
    run_pin(1'b1, 1'b1, 3, "R4 fall high");
    run_pin(1'b0, 1'b1, 4, "R4 fall edge");
    run_pin(1'b1, 1'b1, 3, "R4 rise ignored");
    for (int i = 0; i < 8; i++) cyc(i[0], 1'b1, 1'b0, '0, 1'b0, '0, "R4 R6 toggle fall");

    // R7: load collides with an add
    run_pin(1'b0, 1'b0, 3, "R7 setup");
    cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, "R7 setup");
    cyc(1'b1, 1'b0, 1'b0, '0, 1'b1, 32'h1234_5678, "R7 load wins");
    run_pin(1'b1, 1'b0, 3, "R7 after load");

    // R8: wrap
    cyc(1'b0, 1'b0, 1'b1, 32'd5, 1'b1, 32'hFFFF_FFFE, "R8 preset");
    cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R8 preset");
    run_pin(1'b1, 1'b0, 3, "R8 wrap");
    run_pin(1'b0, 1'b0, 2, "R8 wrap");
    cyc(1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, '0, "R8 step max");
    for (int i = 0; i < 6; i++) cyc(~i[0], 1'b0, 1'b0, '0, 1'b0, '0, "R8 wrap down");
    run_pin(1'b0, 1'b0, 3, "R5 final hold");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule